// File: doc/BRIEF.md
# Clock-Calendar Interrupt Emulator

This block rebuilds the three interrupt sources of a clock-calendar chip from a plain periodic tick. An external base timer delivers one-cycle `tick` pulses, normally at 64 Hz. On each pulse the block checks whether the seconds value has moved on, whether the current time equals the programmed alarm time, and whether a power-of-two periodic interval has elapsed. It then returns a status word in the usual clock-calendar layout, together with a one-cycle strobe. The current time comes from outside: the block does not keep calendar time.

The periodic source is set as a base-two exponent of the wanted rate. At or below the base rate, ticks are counted up to a limit. Above it, the base timer is expected to run at the requested rate, and every tick counts. The timer that delivers the ticks may fall behind. When it does, it reports how many ticks it missed, and those are added to the periodic count so that no interval is lost. Two outputs tell the base timer what to do. `tick_run` says whether it should run at all. `fast_mode` says whether it should run at the periodic rate rather than at the base rate.

Top module: `rtc_irq_emu`

## Requirements
- R1: The status word on `flags_out` has the update flag at bit 4, the alarm flag at bit 5, the periodic flag at bit 6, a general-interrupt bit at bit 7 that is set whenever any of bits 6:4 is set, the value 1 in bits 15:8, and zero in bits 3:0. `flags_vld` is high for the one cycle after a clock edge at which `tick` was high, at least one source was enabled, and at least one of the three flags fired.
- R2: With `freq_log2` f between 1 and 6, the periodic flag fires on a tick whenever the tick count, after that tick is added, reaches 2^(6-f). The count then returns to zero.
- R3: With f above 6, every tick with the periodic source enabled fires the periodic flag. `fast_mode` is then high one cycle after the inputs are applied.
- R4: While the periodic source is enabled, the `missed` value that is present on a tick is added to the count, together with that tick.
- R5: The update flag fires on a tick when `cur_sec` differs from the seconds value recorded on the previous processed tick. Every processed tick records the current seconds value.
- R6: The first tick after `en_update` rises, or after reset, only records the seconds value and never fires the update flag. This holds even if `en_update` rose while no tick was present.
- R7: The alarm flag fires on a tick only when hours, minutes and seconds all equal the alarm inputs.
- R8: With no source enabled, `tick_run` is low and ticks change nothing. While the periodic source is disabled, its count does not advance.
- R9: A `freq_log2` value of 0 is treated as 1, which gives a limit of 32. A value above 13 is treated as 13.
- R10: Reset, which is synchronous and active high, clears `flags_out`, `flags_vld`, `tick_run`, `fast_mode` and the periodic count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle base timer pulse |
| missed | input | MISS_W | Ticks the base timer missed, reported with a tick |
| cur_hr | input | TIME_W | Current hours |
| cur_min | input | TIME_W | Current minutes |
| cur_sec | input | TIME_W | Current seconds |
| en_update | input | 1 | Enable for the seconds-update interrupt |
| en_alarm | input | 1 | Enable for the alarm interrupt |
| en_periodic | input | 1 | Enable for the periodic interrupt |
| alm_hr | input | TIME_W | Alarm hours |
| alm_min | input | TIME_W | Alarm minutes |
| alm_sec | input | TIME_W | Alarm seconds |
| freq_log2 | input | FREQ_W | Periodic rate as a base-two exponent in Hz |
| flags_out | output | 16 | Status word of the last processed tick |
| flags_vld | output | 1 | One-cycle strobe for a nonzero status word |
| tick_run | output | 1 | Base timer should run |
| fast_mode | output | 1 | Base timer should run at the periodic rate |

## Verification
The case that is hardest to reach from the ports is an update enable that drops and rises again between two ticks. No tick sees the disabled state, so the recorded seconds value looks usable even though it must be thrown away. The stimulus toggles `en_update` over idle cycles with `tick` held low. It then presents a new seconds value and expects no update flag, and on the next change it expects the flag. A second difficult case is a periodic count that has to sit unchanged while the periodic source is disabled but other sources keep ticks flowing. This is shown by how many ticks it takes to fire once the source is enabled again.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int BIT_UPD  = 4;
  localparam int BIT_ALM  = 5;
  localparam int BIT_PRD  = 6;
  localparam int BIT_IRQ  = 7;
  localparam logic [7:0] IRQ_COUNT = 8'd1;

  // Clamp the rate exponent into its legal range.
  function automatic int clamp_log2(input int f, input int lo, input int hi);
    if (f < lo) return lo;
    if (f > hi) return hi;
    return f;
  endfunction
endpackage

// File: rtl/rtc_prd_div.sv
module rtc_prd_div
  import rtc_emu_pkg::*;
#(
  parameter int MISS_W    = 8,
  parameter int FREQ_W    = 4,
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic [MISS_W-1:0] missed,
  input  logic [FREQ_W-1:0] f_log2,
  output logic              hit,
  output logic              fast
);
  localparam int CNT_W = BASE_LOG2 + 1;
  localparam int SUM_W = ((CNT_W > MISS_W) ? CNT_W : MISS_W) + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] limit;
  int               f_eff;

  always_comb begin
    f_eff = clamp_log2(int'(f_log2), MIN_LOG2, MAX_LOG2);
    if (f_eff >= BASE_LOG2) limit = SUM_W'(1);
    else                    limit = SUM_W'(1) << (BASE_LOG2 - f_eff);
    sum  = SUM_W'(cnt_q) + SUM_W'(missed) + SUM_W'(1);
    hit  = tick && en && (sum >= limit);
    fast = en && (f_eff > BASE_LOG2);
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (tick && en)  cnt_q <= hit ? '0 : CNT_W'(sum);
  end
endmodule

// File: rtl/rtc_upd_det.sv
module rtc_upd_det #(
  parameter int TIME_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic [TIME_W-1:0] sec,
  output logic              hit
);
  logic              en_q;
  logic              valid_q;
  logic [TIME_W-1:0] last_q;
  logic              rise;

  assign rise = en && !en_q;
  assign hit  = tick && en && valid_q && !rise && (sec != last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= '0;
    end else begin
      en_q <= en;
      if (tick && en) begin
        valid_q <= 1'b1;
        last_q  <= sec;
      end else if (rise) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp #(
  parameter int TIME_W = 6
) (
  input  logic              tick,
  input  logic              en,
  input  logic [TIME_W-1:0] hr,
  input  logic [TIME_W-1:0] mn,
  input  logic [TIME_W-1:0] sc,
  input  logic [TIME_W-1:0] a_hr,
  input  logic [TIME_W-1:0] a_mn,
  input  logic [TIME_W-1:0] a_sc,
  output logic              hit
);
  assign hit = tick && en && (hr == a_hr) && (mn == a_mn) && (sc == a_sc);
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rtc_emu_pkg::*;
#(
  parameter int TIME_W    = 6,
  parameter int MISS_W    = 8,
  parameter int FREQ_W    = 4,
  parameter int BASE_LOG2 = 6,
  parameter int MIN_LOG2  = 1,
  parameter int MAX_LOG2  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [MISS_W-1:0] missed,
  input  logic [TIME_W-1:0] cur_hr,
  input  logic [TIME_W-1:0] cur_min,
  input  logic [TIME_W-1:0] cur_sec,
  input  logic              en_update,
  input  logic              en_alarm,
  input  logic              en_periodic,
  input  logic [TIME_W-1:0] alm_hr,
  input  logic [TIME_W-1:0] alm_min,
  input  logic [TIME_W-1:0] alm_sec,
  input  logic [FREQ_W-1:0] freq_log2,
  output logic [15:0]       flags_out,
  output logic              flags_vld,
  output logic              tick_run,
  output logic              fast_mode
);
  logic any_en, tick_ok;
  logic upd_hit, alm_hit, prd_hit, prd_fast;
  logic [15:0] word;

  assign any_en  = en_update || en_alarm || en_periodic;
  assign tick_ok = tick && any_en;

  rtc_prd_div #(
    .MISS_W(MISS_W), .FREQ_W(FREQ_W), .BASE_LOG2(BASE_LOG2),
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
  ) u_prd (
    .clk(clk), .rst(rst), .tick(tick_ok), .en(en_periodic),
    .missed(missed), .f_log2(freq_log2), .hit(prd_hit), .fast(prd_fast)
  );

  rtc_upd_det #(.TIME_W(TIME_W)) u_upd (
    .clk(clk), .rst(rst), .tick(tick_ok), .en(en_update),
    .sec(cur_sec), .hit(upd_hit)
  );

  rtc_alm_cmp #(.TIME_W(TIME_W)) u_alm (
    .tick(tick_ok), .en(en_alarm),
    .hr(cur_hr), .mn(cur_min), .sc(cur_sec),
    .a_hr(alm_hr), .a_mn(alm_min), .a_sc(alm_sec),
    .hit(alm_hit)
  );

  always_comb begin
    word = '0;
    word[BIT_UPD] = upd_hit;
    word[BIT_ALM] = alm_hit;
    word[BIT_PRD] = prd_hit;
    if (upd_hit || alm_hit || prd_hit) begin
      word[BIT_IRQ] = 1'b1;
      word[15:8]    = IRQ_COUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_out <= '0;
      flags_vld <= 1'b0;
      tick_run  <= 1'b0;
      fast_mode <= 1'b0;
    end else begin
      if (tick_ok) flags_out <= word;
      flags_vld <= tick_ok && (upd_hit || alm_hit || prd_hit);
      tick_run  <= any_en;
      fast_mode <= prd_fast;
    end
  end
endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk #(
  parameter int TIME_W = 6,
  parameter int FREQ_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [TIME_W-1:0] cur_hr,
  input logic [TIME_W-1:0] cur_min,
  input logic [TIME_W-1:0] cur_sec,
  input logic              en_update,
  input logic              en_alarm,
  input logic              en_periodic,
  input logic [TIME_W-1:0] alm_hr,
  input logic [TIME_W-1:0] alm_min,
  input logic [TIME_W-1:0] alm_sec,
  input logic [FREQ_W-1:0] freq_log2,
  input logic [15:0]       flags_out,
  input logic              flags_vld,
  input logic              tick_run
);
  assert_word_form_R1: assert property (@(posedge clk) disable iff (rst)
    flags_vld |-> (flags_out[15:8] == 8'd1) && flags_out[7] &&
                  (flags_out[3:0] == 4'd0) && (flags_out[6:4] != 3'd0));

  assert_strobe_tick_R1: assert property (@(posedge clk) disable iff (rst)
    flags_vld |-> $past(tick));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !(en_update || en_alarm || en_periodic) |=> !flags_vld && !tick_run);

  assert_alarm_match_R7: assert property (@(posedge clk) disable iff (rst)
    (flags_vld && flags_out[5]) |->
      $past(cur_hr == alm_hr && cur_min == alm_min && cur_sec == alm_sec));

  assert_fast_fires_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && en_periodic && freq_log2 > FREQ_W'(6)) |=> flags_vld && flags_out[6]);

  assert_first_update_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && en_update && !$past(en_update)) |=> !flags_out[4]);
endmodule

bind rtc_irq_emu rtc_irq_emu_chk #(.TIME_W(TIME_W), .FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick),
  .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
  .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
  .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
  .freq_log2(freq_log2), .flags_out(flags_out), .flags_vld(flags_vld),
  .tick_run(tick_run)
);

// File: tb/rtc_irq_emu_bench.sv
module rtc_irq_emu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic       u, a, p;
    logic [3:0] f;
    logic [7:0] miss;
    logic [5:0] h, m, s;
    logic       vld;
    logic [15:0] flags;
  } vec_t;

  // Alarm time is fixed at 10:20:30 for the whole run.
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,4'd0,8'd0,6'd0, 6'd0, 6'd5, 1'b0,16'h0000}, // R6 first tick records
    '{1'b1,1'b0,1'b0,4'd0,8'd0,6'd0, 6'd0, 6'd5, 1'b0,16'h0000}, // R5 same second
    '{1'b1,1'b0,1'b0,4'd0,8'd0,6'd0, 6'd0, 6'd6, 1'b1,16'h0190}, // R5 new second
    '{1'b1,1'b0,1'b0,4'd0,8'd0,6'd0, 6'd0, 6'd6, 1'b0,16'h0000}, // R5
    '{1'b0,1'b1,1'b0,4'd0,8'd0,6'd10,6'd20,6'd30,1'b1,16'h01A0}, // R7 match
    '{1'b0,1'b1,1'b0,4'd0,8'd0,6'd10,6'd20,6'd31,1'b0,16'h0000}, // R7 sec differs
    '{1'b0,1'b1,1'b0,4'd0,8'd0,6'd10,6'd21,6'd30,1'b0,16'h0000}, // R7 min differs
    '{1'b0,1'b1,1'b0,4'd0,8'd0,6'd11,6'd20,6'd30,1'b0,16'h0000}, // R7 hr differs
    '{1'b0,1'b0,1'b1,4'd5,8'd0,6'd0, 6'd0, 6'd0, 1'b0,16'h0000}, // R2 limit 2, cnt 1
    '{1'b0,1'b0,1'b1,4'd5,8'd0,6'd0, 6'd0, 6'd0, 1'b1,16'h01C0}, // R2 reaches 2
    '{1'b0,1'b0,1'b1,4'd5,8'd1,6'd0, 6'd0, 6'd0, 1'b1,16'h01C0}, // R4 0+1+1
    '{1'b0,1'b0,1'b1,4'd6,8'd0,6'd0, 6'd0, 6'd0, 1'b1,16'h01C0}, // R2 limit 1
    '{1'b0,1'b0,1'b1,4'd9,8'd0,6'd0, 6'd0, 6'd0, 1'b1,16'h01C0}, // R3 fast
    '{1'b0,1'b0,1'b1,4'd4,8'd0,6'd0, 6'd0, 6'd0, 1'b0,16'h0000}, // R2 limit 4, cnt 1
    '{1'b0,1'b0,1'b1,4'd4,8'd2,6'd0, 6'd0, 6'd0, 1'b1,16'h01C0}, // R4 1+1+2
    '{1'b1,1'b1,1'b1,4'd5,8'd0,6'd10,6'd20,6'd30,1'b1,16'h01A0}, // R6 re-enable, alarm
    '{1'b1,1'b1,1'b1,4'd5,8'd0,6'd10,6'd20,6'd31,1'b1,16'h01D0}, // R1 update+periodic
    '{1'b1,1'b1,1'b1,4'd5,8'd0,6'd10,6'd20,6'd30,1'b1,16'h01B0}, // R1 update+alarm
    '{1'b1,1'b1,1'b1,4'd5,8'd0,6'd10,6'd20,6'd30,1'b1,16'h01E0}, // R1 alarm+periodic
    '{1'b0,1'b0,1'b0,4'd5,8'd0,6'd10,6'd20,6'd31,1'b0,16'h0000}  // R8 all off
  };
  localparam string TAG [NV] = '{"R6","R5","R5","R5","R7","R7","R7","R7",
    "R2","R2","R4","R2","R3","R2","R4","R6","R1","R1","R1","R8"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [7:0] missed = '0;
  logic [5:0] cur_hr = '0, cur_min = '0, cur_sec = '0;
  logic en_update = 1'b0, en_alarm = 1'b0, en_periodic = 1'b0;
  logic [5:0] alm_hr = 6'd10, alm_min = 6'd20, alm_sec = 6'd30;
  logic [3:0] freq_log2 = '0;
  logic [15:0] flags_out;
  logic flags_vld, tick_run, fast_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_emu u_rtc_irq_emu (
    .clk(clk), .rst(rst), .tick(tick), .missed(missed),
    .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
    .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
    .freq_log2(freq_log2), .flags_out(flags_out), .flags_vld(flags_vld),
    .tick_run(tick_run), .fast_mode(fast_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive inputs with a tick at a falling edge; sample one cycle later.
  task automatic pulse(input logic u, a, p, input logic [3:0] f, input logic [7:0] m8,
                       input logic [5:0] h, mi, s);
    @(negedge clk);
    en_update = u; en_alarm = a; en_periodic = p; freq_log2 = f;
    missed = m8; cur_hr = h; cur_min = mi; cur_sec = s; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; missed = '0;
  endtask

  task automatic expect_out(input string req, input logic vld, input logic [15:0] fl);
    check(req, {31'd0, flags_vld}, {31'd0, vld});
    if (vld) check(req, {16'd0, flags_out}, {16'd0, fl});
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int quiet;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {16'd0, flags_out}, 32'd0);
    check("R10", {29'd0, flags_vld, tick_run, fast_mode}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i].u, VEC[i].a, VEC[i].p, VEC[i].f, VEC[i].miss,
            VEC[i].h, VEC[i].m, VEC[i].s);
      expect_out(TAG[i], VEC[i].vld, VEC[i].flags);
    end
    // R8 all disabled: tick_run low
    check("R8", {31'd0, tick_run}, 32'd0);

    // R8 periodic count frozen while disabled (limit 4, count 0 here)
    pulse(1'b0,1'b0,1'b1,4'd4,8'd0,6'd0,6'd0,6'd0);
    expect_out("R8", 1'b0, 16'h0);
    quiet = 0;
    for (int k = 0; k < 5; k++) begin
      pulse(1'b0,1'b1,1'b0,4'd4,8'd0,6'd1,6'd0,6'd0);
      if (flags_vld) quiet++;
    end
    check("R8", quiet, 0);
    check("R8", {31'd0, tick_run}, 32'd1);
    pulse(1'b0,1'b0,1'b1,4'd4,8'd0,6'd0,6'd0,6'd0);
    expect_out("R8", 1'b0, 16'h0);
    pulse(1'b0,1'b0,1'b1,4'd4,8'd0,6'd0,6'd0,6'd0);
    expect_out("R8", 1'b0, 16'h0);
    pulse(1'b0,1'b0,1'b1,4'd4,8'd0,6'd0,6'd0,6'd0);
    expect_out("R8", 1'b1, 16'h01C0);

    // R9 exponent 0 acts as 1: limit 32
    quiet = 0;
    for (int k = 0; k < 31; k++) begin
      pulse(1'b0,1'b0,1'b1,4'd0,8'd0,6'd0,6'd0,6'd0);
      if (flags_vld) quiet++;
    end
    check("R9", quiet, 0);
    pulse(1'b0,1'b0,1'b1,4'd0,8'd0,6'd0,6'd0,6'd0);
    expect_out("R9", 1'b1, 16'h01C0);

    // R9 / R3 exponent 15 clamps to 13: every tick, fast mode
    pulse(1'b0,1'b0,1'b1,4'd15,8'd0,6'd0,6'd0,6'd0);
    expect_out("R9", 1'b1, 16'h01C0);
    check("R3", {31'd0, fast_mode}, 32'd1);
    @(negedge clk); en_periodic = 1'b0;
    @(negedge clk);
    check("R3", {31'd0, fast_mode}, 32'd0);

    // R6 enable toggled between ticks invalidates the recorded second
    pulse(1'b1,1'b0,1'b0,4'd0,8'd0,6'd0,6'd0,6'd1);
    expect_out("R6", 1'b0, 16'h0);
    pulse(1'b1,1'b0,1'b0,4'd0,8'd0,6'd0,6'd0,6'd2);
    expect_out("R5", 1'b1, 16'h0190);
    @(negedge clk); en_update = 1'b0;
    @(negedge clk); en_update = 1'b1;
    @(negedge clk);
    pulse(1'b1,1'b0,1'b0,4'd0,8'd0,6'd0,6'd0,6'd3);
    expect_out("R6", 1'b0, 16'h0);
    pulse(1'b1,1'b0,1'b0,4'd0,8'd0,6'd0,6'd0,6'd4);
    expect_out("R5", 1'b1, 16'h0190);

    // R10 reset mid-run, enable held high
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10", {15'd0, flags_out, flags_vld}, 32'd0);
    check("R10", {31'd0, tick_run}, 32'd0);
    rst = 1'b0;
    pulse(1'b1,1'b0,1'b0,4'd0,8'd0,6'd0,6'd0,6'd9);
    expect_out("R6", 1'b0, 16'h0);
    pulse(1'b1,1'b0,1'b0,4'd0,8'd0,6'd0,6'd0,6'd10);
    expect_out("R5", 1'b1, 16'h0190);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule